// File: doc/BRIEF.md
# Settable 24-Hour Time-of-Day Counter

This block keeps the time of day from a free-running system clock (12 MHz by default). A prescaler chain produces single-cycle pulses once per microsecond, once per millisecond and once per second. The second pulse drives a BCD time register that holds hours, minutes and seconds as six digits and runs from 00:00:00 to 23:59:59. The digits feed a display, and the microsecond and millisecond pulses are exported so that other logic can share the same timebase.

Two push buttons set the time. Each raw button line passes through a two-flop synchroniser and then through a debounce state machine with four states. `DB_IDLE_LO` moves to `DB_WAIT_HI` when the synchronised level goes high. `DB_WAIT_HI` returns to `DB_IDLE_LO` if the level drops, or moves to `DB_IDLE_HI` after `DEBOUNCE_MS` millisecond pulses with the level held high, and it emits the advance pulse on that transition. `DB_IDLE_HI` moves to `DB_WAIT_LO` when the level goes low. `DB_WAIT_LO` returns to `DB_IDLE_HI` if the level rises, or moves to `DB_IDLE_LO` after `DEBOUNCE_MS` millisecond pulses with the level held low.

An accepted press on the hour button steps only the hours, and an accepted press on the minute button steps only the minutes. Neither carries into the next field. Either press forces the seconds to zero.

Top module: `tod_clock`

## Requirements
- R1: `us_tick` is high for exactly one cycle in every `CLK_PER_US` cycles. The first pulse falls in the `CLK_PER_US`-th cycle after reset is released.
- R2: `ms_tick` is high only together with a `us_tick`, on every `US_PER_MS`-th one. `s_tick` is high only together with an `ms_tick`, on every `MS_PER_S`-th one.
- R3: On `s_tick` the seconds (tens digit in `sec_tens`, units digit in `sec_ones`, both BCD) count 00 to 59. The seconds wrap to 00 and carry one into the minutes.
- R4: Minutes wrap 59 to 00 and carry into the hours. Hours wrap 23 to 00, so 23:59:59 is followed by 00:00:00.
- R5: An accepted hour press steps the hours by one and wraps 23 to 00. The minutes are left unchanged.
- R6: An accepted minute press steps the minutes by one and wraps 59 to 00. The hours are left unchanged.
- R7: Any accepted press clears the seconds to 00. If the press lands in the same cycle as `s_tick`, the press wins and that second (with any carry) is dropped.
- R8: The raw button is delayed by two synchronising flops. After the synchronised level changes, the cycle that follows starts a count of millisecond pulses. The change is accepted on the `DEBOUNCE_MS`-th pulse with the level still unchanged, and a level change before that aborts the count. A press is accepted only on a low-to-high acceptance, and a held button yields one step.
- R9: A synchronous `rst` clears all counters, the synchronisers and the debouncers, and shows 00:00:00.
- R10: Presses on both buttons accepted in the same cycle step both fields and clear the seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_hour | input | 1 | Raw hour-set button, active high |
| btn_minute | input | 1 | Raw minute-set button, active high |
| us_tick | output | 1 | One-cycle microsecond pulse |
| ms_tick | output | 1 | One-cycle millisecond pulse |
| s_tick | output | 1 | One-cycle second pulse |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_ones | output | 4 | Hours units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_ones | output | 4 | Seconds units digit, BCD |

## Verification
Both button acceptance and the second pulse happen only on a millisecond pulse, so a press can land in the same cycle as `s_tick`. In that case R7 requires the press to win and the second to be lost. The bench provokes the collision on purpose. It waits for an `s_tick`, counts three millisecond pulses and then raises a button, which places acceptance exactly on the next second pulse. A cycle-level reference model built from the requirements judges the digits after that edge, and the bench confirms that the collision actually took place. Random bouncing stimulus adds further coincidences, including both buttons together and presses on a 59-second boundary.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    typedef enum logic [1:0] {
        DB_IDLE_LO,
        DB_WAIT_HI,
        DB_IDLE_HI,
        DB_WAIT_LO
    } db_state_e;

    // true when the pair holds its last value before wrapping
    function automatic logic bcd_at_top(bcd2_t v, logic [3:0] top_t, logic [3:0] top_o);
        return (v.tens == top_t) && (v.ones == top_o);
    endfunction

    function automatic bcd2_t bcd_step(bcd2_t v, logic [3:0] top_t, logic [3:0] top_o);
        bcd2_t r;
        if (bcd_at_top(v, top_t, top_o)) begin
            r = '0;
        end else if (v.ones == 4'd9) begin
            r.tens = v.tens + 4'd1;
            r.ones = 4'd0;
        end else begin
            r.tens = v.tens;
            r.ones = v.ones + 4'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tod_tick_gen.sv
module tod_tick_gen #(
    parameter int CLK_PER_US = 12,
    parameter int US_PER_MS  = 1000,
    parameter int MS_PER_S   = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic us_tick,
    output logic ms_tick,
    output logic s_tick
);
    localparam int UW = $clog2(CLK_PER_US > 1 ? CLK_PER_US : 2);
    localparam int MW = $clog2(US_PER_MS  > 1 ? US_PER_MS  : 2);
    localparam int SW = $clog2(MS_PER_S   > 1 ? MS_PER_S   : 2);

    logic [UW-1:0] us_cnt;
    logic [MW-1:0] ms_cnt;
    logic [SW-1:0] s_cnt;

    assign us_tick = (us_cnt == UW'(CLK_PER_US - 1));
    assign ms_tick = us_tick && (ms_cnt == MW'(US_PER_MS - 1));
    assign s_tick  = ms_tick && (s_cnt == SW'(MS_PER_S - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            us_cnt <= '0;
            ms_cnt <= '0;
            s_cnt  <= '0;
        end else begin
            us_cnt <= us_tick ? '0 : us_cnt + UW'(1);
            if (us_tick) ms_cnt <= ms_tick ? '0 : ms_cnt + MW'(1);
            if (ms_tick) s_cnt  <= s_tick  ? '0 : s_cnt + SW'(1);
        end
    end

    generate
        if (CLK_PER_US > 1) begin : g_gap_chk
            p_us_gap_r1: assert property (@(posedge clk) disable iff (rst)
                us_tick |=> !us_tick);
            p_ms_gap_r2: assert property (@(posedge clk) disable iff (rst)
                ms_tick |=> !ms_tick && !s_tick);
        end
    endgenerate

endmodule

// File: rtl/tod_btn_cond.sv
module tod_btn_cond #(
    parameter int DEBOUNCE_MS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic btn_raw,
    output logic press
);
    import tod_pkg::*;

    localparam int CW = $clog2(DEBOUNCE_MS + 1);

    logic [1:0]    sync_q;
    logic          lvl;
    logic [CW-1:0] cnt;
    logic          done;
    db_state_e     state, state_nx;

    assign lvl  = sync_q[1];
    assign done = ms_tick && (cnt == CW'(DEBOUNCE_MS - 1));

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], btn_raw};
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DB_IDLE_LO: if (lvl)  state_nx = DB_WAIT_HI;
            DB_WAIT_HI: if (!lvl) state_nx = DB_IDLE_LO;
                        else if (done) state_nx = DB_IDLE_HI;
            DB_IDLE_HI: if (!lvl) state_nx = DB_WAIT_LO;
            DB_WAIT_LO: if (lvl)  state_nx = DB_IDLE_HI;
                        else if (done) state_nx = DB_IDLE_LO;
            default:    state_nx = DB_IDLE_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= DB_IDLE_LO;
        else     state <= state_nx;
    end

    // stability counter: restarts whenever a wait state is entered
    always_ff @(posedge clk) begin
        if (rst || (state_nx != state)) cnt <= '0;
        else if (ms_tick && (state == DB_WAIT_HI || state == DB_WAIT_LO)) cnt <= cnt + CW'(1);
    end

    always_comb begin
        press = (state == DB_WAIT_HI) && (state_nx == DB_IDLE_HI);
    end

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);
    p_press_on_ms_r8: assert property (@(posedge clk) disable iff (rst)
        press |-> ms_tick && lvl);

endmodule

// File: rtl/tod_counter.sv
module tod_counter (
    input  logic           clk,
    input  logic           rst,
    input  logic           s_tick,
    input  logic           adv_hr,
    input  logic           adv_min,
    output tod_pkg::bcd2_t hr,
    output tod_pkg::bcd2_t mn,
    output tod_pkg::bcd2_t sec
);
    import tod_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            hr  <= '0;
            mn  <= '0;
            sec <= '0;
        end else if (adv_hr || adv_min) begin
            sec <= '0;
            if (adv_hr)  hr <= bcd_step(hr, 4'd2, 4'd3);
            if (adv_min) mn <= bcd_step(mn, 4'd5, 4'd9);
        end else if (s_tick) begin
            sec <= bcd_step(sec, 4'd5, 4'd9);
            if (bcd_at_top(sec, 4'd5, 4'd9)) begin
                mn <= bcd_step(mn, 4'd5, 4'd9);
                if (bcd_at_top(mn, 4'd5, 4'd9)) hr <= bcd_step(hr, 4'd2, 4'd3);
            end
        end
    end

    p_sec_bcd_r3: assert property (@(posedge clk) disable iff (rst)
        sec.tens <= 4'd5 && sec.ones <= 4'd9);
    p_hr_range_r4: assert property (@(posedge clk) disable iff (rst)
        hr.tens < 4'd2 ? hr.ones <= 4'd9 : (hr.tens == 4'd2 && hr.ones <= 4'd3));
    p_hr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        adv_hr && hr.tens == 4'd2 && hr.ones == 4'd3 |=> hr == '0);
    p_no_carry_r6: assert property (@(posedge clk) disable iff (rst)
        adv_min && !adv_hr |=> $stable(hr));
    p_press_clears_r7: assert property (@(posedge clk) disable iff (rst)
        adv_hr || adv_min |=> sec == '0);
    p_reset_zero_r9: assert property (@(posedge clk)
        rst |=> hr == '0 && mn == '0 && sec == '0);

endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
    parameter int CLK_PER_US  = 12,
    parameter int US_PER_MS   = 1000,
    parameter int MS_PER_S    = 1000,
    parameter int DEBOUNCE_MS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_hour,
    input  logic       btn_minute,
    output logic       us_tick,
    output logic       ms_tick,
    output logic       s_tick,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_ones
);
    import tod_pkg::*;

    localparam int NBTN = 2;

    logic [NBTN-1:0] raw;
    logic [NBTN-1:0] adv;
    bcd2_t           hr, mn, sec;

    assign raw = {btn_minute, btn_hour};

    tod_tick_gen #(
        .CLK_PER_US(CLK_PER_US),
        .US_PER_MS (US_PER_MS),
        .MS_PER_S  (MS_PER_S)
    ) u_ticks (
        .clk    (clk),
        .rst    (rst),
        .us_tick(us_tick),
        .ms_tick(ms_tick),
        .s_tick (s_tick)
    );

    generate
        for (genvar b = 0; b < NBTN; b++) begin : g_btn
            tod_btn_cond #(.DEBOUNCE_MS(DEBOUNCE_MS)) u_cond (
                .clk    (clk),
                .rst    (rst),
                .ms_tick(ms_tick),
                .btn_raw(raw[b]),
                .press  (adv[b])
            );
        end
    endgenerate

    tod_counter u_time (
        .clk    (clk),
        .rst    (rst),
        .s_tick (s_tick),
        .adv_hr (adv[0]),
        .adv_min(adv[1]),
        .hr     (hr),
        .mn     (mn),
        .sec    (sec)
    );

    assign hr_tens  = hr.tens;
    assign hr_ones  = hr.ones;
    assign min_tens = mn.tens;
    assign min_ones = mn.ones;
    assign sec_tens = sec.tens;
    assign sec_ones = sec.ones;

endmodule

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;
    localparam int C = 2;
    localparam int U = 4;
    localparam int M = 5;
    localparam int D = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_hour = 1'b0;
    logic btn_minute = 1'b0;
    logic us_tick, ms_tick, s_tick;
    logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;

    int checks = 0;
    int errors = 0;
    int collide = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tod_clock #(.CLK_PER_US(C), .US_PER_MS(U), .MS_PER_S(M), .DEBOUNCE_MS(D)) dut (
        .clk(clk), .rst(rst), .btn_hour(btn_hour), .btn_minute(btn_minute),
        .us_tick(us_tick), .ms_tick(ms_tick), .s_tick(s_tick),
        .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
        .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones)
    );

    // ---------------- reference model built from the requirements
    int m_us, m_ms, m_s;
    int hh, mm, ss;
    bit s1 [2];
    bit s2 [2];
    bit lv [2];
    bit wt [2];
    int dc [2];

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic bit exp_us();
        return m_us == C - 1;
    endfunction
    function automatic bit exp_ms();
        return exp_us() && m_ms == U - 1;
    endfunction
    function automatic bit exp_s();
        return exp_ms() && m_s == M - 1;
    endfunction

    always @(posedge clk) begin
        bit ut, mt, st;
        bit p [2];
        if (rst) begin
            m_us = 0; m_ms = 0; m_s = 0;
            hh = 0; mm = 0; ss = 0;
            for (int b = 0; b < 2; b++) begin
                s1[b] = 0; s2[b] = 0; lv[b] = 0; wt[b] = 0; dc[b] = 0;
            end
        end else begin
            ut = exp_us(); mt = exp_ms(); st = exp_s();
            for (int b = 0; b < 2; b++)
                p[b] = wt[b] && s2[b] && !lv[b] && mt && dc[b] == D - 1;
            if (p[0] || p[1]) begin
                if (st) collide++;
                if (p[0]) hh = (hh + 1) % 24;
                if (p[1]) mm = (mm + 1) % 60;
                ss = 0;
            end else if (st) begin
                int t;
                t = (hh * 3600 + mm * 60 + ss + 1) % 86400;
                hh = t / 3600; mm = (t / 60) % 60; ss = t % 60;
            end
            for (int b = 0; b < 2; b++) begin
                if (s2[b] != lv[b]) begin
                    if (!wt[b]) begin
                        wt[b] = 1; dc[b] = 0;
                    end else if (mt) begin
                        if (dc[b] == D - 1) begin lv[b] = s2[b]; wt[b] = 0; end
                        else dc[b]++;
                    end
                end else begin
                    wt[b] = 0;
                end
                s2[b] = s1[b];
            end
            s1[0] = btn_hour; s1[1] = btn_minute;
            m_us = ut ? 0 : m_us + 1;
            if (ut) m_ms = mt ? 0 : m_ms + 1;
            if (mt) m_s = st ? 0 : m_s + 1;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // continuous cycle-level comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (!done) begin
            check(us_tick == exp_us(), "R1", "us_tick", us_tick, exp_us());
            check({ms_tick, s_tick} == {exp_ms(), exp_s()}, "R2", "ms/s tick",
                  {ms_tick, s_tick}, {exp_ms(), exp_s()});
            check({hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones} ==
                  {to_bcd(hh), to_bcd(mm), to_bcd(ss)}, "R3/R4/R5/R6/R7",
                  "hhmmss", {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones},
                  {to_bcd(hh), to_bcd(mm), to_bcd(ss)});
        end
    end

    task automatic press(int b, int hold);
        @(negedge clk);
        if (b == 0) btn_hour = 1; else btn_minute = 1;
        repeat (hold) @(negedge clk);
        btn_hour = 0; btn_minute = 0;
        repeat (30) @(negedge clk);
    endtask

    function automatic int disp_h();
        return hr_tens * 10 + hr_ones;
    endfunction
    function automatic int disp_m();
        return min_tens * 10 + min_ones;
    endfunction
    function automatic int disp_s();
        return sec_tens * 10 + sec_ones;
    endfunction

    initial begin
        int h0, m0;
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        check(disp_h() == 0 && disp_m() == 0 && disp_s() == 0, "R9", "reset digits",
              disp_h() * 10000 + disp_m() * 100 + disp_s(), 0);
        check(!us_tick && !ms_tick && !s_tick, "R9", "reset ticks", us_tick, 0);
        rst = 0;

        // R8: short glitch shorter than one ms period is ignored
        m0 = disp_m();
        @(negedge clk); btn_minute = 1;
        repeat (4) @(negedge clk); btn_minute = 0;
        repeat (40) @(negedge clk);
        check(disp_m() == m0, "R8", "glitch ignored", disp_m(), m0);

        // R8: long hold gives exactly one step
        m0 = disp_m();
        press(1, 200);
        check(disp_m() == (m0 + 1) % 60, "R8", "held button one step", disp_m(), (m0 + 1) % 60);

        // R5: hours to 23 then wrap
        while (disp_h() != 23) press(0, 30);
        m0 = disp_m();
        press(0, 30);
        check(disp_h() == 0, "R5", "hour wrap 23->00", disp_h(), 0);
        check(disp_m() == m0, "R5", "minutes untouched", disp_m(), m0);
        press(0, 30);
        check(disp_h() == 1, "R5", "hour step", disp_h(), 1);
        while (disp_h() != 23) press(0, 30);

        // R6: minutes to 59 then wrap without carry
        while (disp_m() != 59) press(1, 30);
        h0 = disp_h();
        press(1, 30);
        check(disp_m() == 0 && disp_h() == h0, "R6", "minute wrap no carry",
              disp_h() * 100 + disp_m(), h0 * 100);
        check(disp_s() < 3, "R7", "seconds cleared", disp_s(), 0);
        while (disp_m() != 59) press(1, 30);

        // R4: run through midnight
        repeat (61 * C * U * M + 20) @(negedge clk);
        check(disp_h() == 0 && disp_m() == 0, "R4", "midnight rollover",
              disp_h() * 100 + disp_m(), 0);

        // R7: press accepted in the same cycle as s_tick
        for (int k = 0; k < 2; k++) begin
            int c0;
            c0 = collide;
            while (!s_tick) @(negedge clk);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                while (!ms_tick) @(negedge clk);
            end
            if (k == 0) btn_hour = 1; else btn_minute = 1;
            repeat (40) @(negedge clk);
            btn_hour = 0; btn_minute = 0;
            repeat (40) @(negedge clk);
            check(collide > c0, "R7", "press on s_tick provoked", collide, c0 + 1);
        end

        // R10: both buttons together
        h0 = disp_h(); m0 = disp_m();
        @(negedge clk); btn_hour = 1; btn_minute = 1;
        repeat (40) @(negedge clk);
        btn_hour = 0; btn_minute = 0;
        repeat (40) @(negedge clk);
        check(disp_h() == (h0 + 1) % 24 && disp_m() == (m0 + 1) % 60, "R10", "dual press",
              disp_h() * 100 + disp_m(), ((h0 + 1) % 24) * 100 + (m0 + 1) % 60);

        // random bouncing stimulus, judged by the model every cycle
        for (int it = 0; it < 60; it++) begin
            int len;
            len = 1 + int'($urandom_range(0, 40));
            for (int j = 0; j < len; j++) begin
                @(negedge clk);
                btn_hour   = $urandom_range(0, 3) != 0 ? btn_hour   : ~btn_hour;
                btn_minute = $urandom_range(0, 3) != 0 ? btn_minute : ~btn_minute;
            end
            repeat ($urandom_range(0, 60)) @(negedge clk);
        end
        btn_hour = 0; btn_minute = 0;
        repeat (100) @(negedge clk);

        // R9: reset mid-run
        rst = 1;
        repeat (2) @(negedge clk);
        check(disp_h() == 0 && disp_m() == 0 && disp_s() == 0, "R9", "reset mid-run",
              disp_h() * 10000 + disp_m() * 100 + disp_s(), 0);
        rst = 0;
        repeat (20) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule